// File: doc/BRIEF.md
# Serial Configuration Bit-Stream Memory Reader

This block is the read side of a one-time-programmable serial configuration memory. It holds a bit array whose depth is set by a parameter. It presents one bit at a time on a serial output. An internal bit-address counter steps once per rising clock edge while the block is selected. A host that configures itself drives the clock, holds the memory in reset until it is ready, then clocks bits out until it has what it needs. After that it deselects the memory.

There are two control inputs. The chip enable, active low, selects the memory. When it is high, the counter freezes, the output is released and a standby flag is raised. The combined reset/output-enable input zeroes the counter and releases the output. Its active level is chosen by a parameter. The counter does not wrap. Once it steps past the highest address it stays there, and that resting position reads the bit at address 0. The driver enable is brought out as a plain flag in place of a tri-state pad. A small write port loads the array, and it works only in standby. A power-on reset clears the counter.

Top module: `cfg_prom_reader`

## Requirements
- R1: While `por_n` is low the address counter is zero. With the reset/output-enable input active and `ce_n` high, `sdo_en` is 0, `sdo` is 0 and `standby` is 1.
- R2: `sdo_en` is 1 exactly when `ce_n` is low and the reset/output-enable input is inactive. When `sdo_en` is 0, `sdo` reads 0.
- R3: On each rising `clk` edge where `ce_n` is low and reset is inactive, the address counter advances by one, if it is below `DEPTH`. `sdo` then shows array bit [address].
- R4: While reset is active the counter is held at zero. Releasing reset with `ce_n` low presents bit 0 before any further clock edge.
- R5: While `ce_n` is high and reset is inactive, clock edges leave the counter unchanged. `standby` equals `ce_n`. Reselecting resumes at the frozen address.
- R6: The counter reaches `DEPTH` (highest address plus one) and then stops. At that position `sdo` shows array bit 0.
- R7: With `RST_ACTIVE_HIGH`=1 the reset/output-enable input is active at 1. With 0 it is active at 0, and otherwise the behaviour is identical.
- R8: A write (`wr_en`=1 at a rising edge) stores `wr_bit` at `wr_addr` only when `ce_n` is high. A write while `ce_n` is low changes no stored bit.
- R9: If reset is active while `ce_n` is high, the counter still returns to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; counter steps on rising edge |
| por_n | input | 1 | Power-on reset, active low, clears the counter |
| ce_n | input | 1 | Chip enable, active low; high means standby |
| rst_oe | input | 1 | Counter reset / output enable, polarity per `RST_ACTIVE_HIGH` |
| wr_en | input | 1 | Array write strobe, honoured in standby only |
| wr_addr | input | $clog2(DEPTH) | Array write address |
| wr_bit | input | 1 | Array write data |
| sdo | output | 1 | Serial data bit, 0 when not driven |
| sdo_en | output | 1 | Output driver enable (1 = driven) |
| standby | output | 1 | Standby indicator |

## Verification
The driver enable and standby flag follow the control inputs with no clock delay. The bench therefore checks them in the same cycle the inputs change, including the bit-0 read right after reset is released. Counter moves take effect at the rising edge that samples the controls. The bench drives every input on the falling edge, lets exactly one rising edge pass, and compares on the next falling edge. The two instances, one per reset polarity, receive complementary reset levels and must give the same outputs in every checked cycle.

// File: rtl/cfg_prom_reader.sv
module cfg_prom_reader #(
  parameter int DEPTH           = 64,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int AW             = $clog2(DEPTH),
  localparam int CW             = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  output logic          sdo,
  output logic          sdo_en,
  output logic          standby
);

  localparam logic [CW-1:0] END_CNT = CW'(DEPTH);

  logic [DEPTH-1:0] bits_q;
  logic [CW-1:0]    addr_q;
  logic             rst_act;
  logic             step;
  logic [AW-1:0]    rd_idx;

  assign rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;
  assign step    = ~rst_act & ~ce_n & (addr_q < END_CNT);
  assign rd_idx  = (addr_q == END_CNT) ? '0 : addr_q[AW-1:0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       addr_q <= '0;
    else if (rst_act) addr_q <= '0;
    else if (step)    addr_q <= addr_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en && ce_n) bits_q[wr_addr] <= wr_bit;
  end

  assign sdo_en  = ~rst_act & ~ce_n;
  assign sdo     = sdo_en & bits_q[rd_idx];
  assign standby = ce_n;

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
    rst_act |=> addr_q == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_act && !ce_n && addr_q < END_CNT) |=> addr_q == $past(addr_q) + CW'(1));

  p_freeze_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_act && ce_n) |=> $stable(addr_q));

  p_stop_r6: assert property (@(posedge clk) disable iff (!por_n)
    (addr_q == END_CNT && !rst_act) |=> addr_q == END_CNT);

  p_bound_r6: assert property (@(posedge clk) disable iff (!por_n)
    addr_q <= END_CNT);

  p_no_wr_r8: assert property (@(posedge clk) disable iff (!por_n)
    (!ce_n) |=> bits_q == $past(bits_q));

endmodule

// File: tb/cfg_prom_reader_tb_top.sv
module cfg_prom_reader_tb_top;
  localparam int D  = 16;
  localparam int AW = $clog2(D);
  localparam logic [D-1:0] PAT = 16'h4B35;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ce_n = 1'b1;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic wr_bit = 1'b0;
  logic sdo_h, en_h, sb_h, sdo_l, en_l, sb_l;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_prom_reader #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1)) dut_i (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_bit(wr_bit), .sdo(sdo_h), .sdo_en(en_h), .standby(sb_h));

  cfg_prom_reader #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b0)) dut_lo (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(~rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_bit(wr_bit), .sdo(sdo_l), .sdo_en(en_l), .standby(sb_l));

  // [7] ce_n, [6] reset active, [5] expected enable, [4:0] expected address
  localparam logic [7:0] VEC [10] = '{
    {1'b0, 1'b1, 1'b0, 5'd0},
    {1'b0, 1'b0, 1'b1, 5'd1},
    {1'b0, 1'b0, 1'b1, 5'd2},
    {1'b1, 1'b0, 1'b0, 5'd2},
    {1'b1, 1'b0, 1'b0, 5'd2},
    {1'b0, 1'b0, 1'b1, 5'd3},
    {1'b1, 1'b1, 1'b0, 5'd0},
    {1'b0, 1'b0, 1'b1, 5'd1},
    {1'b0, 1'b1, 1'b0, 5'd0},
    {1'b0, 1'b0, 1'b1, 5'd1}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // compares {sdo_en, sdo, standby} of both instances
  task automatic chk_out(input string req, input logic en, input logic b, input logic sb);
    chk({req, " hi"}, {1'b0, en_h, sdo_h, sb_h}, {1'b0, en, en & b, sb});
    chk({req, " lo"}, {1'b0, en_l, sdo_l, sb_l}, {1'b0, en, en & b, sb});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart();
    rst = 1'b1; ce_n = 1'b0;
    tick();
    rst = 1'b0;
    #1;
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < D; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_bit = PAT[i];
      tick();
    end
    wr_en = 1'b0;
    chk_out("R1 reset state", 1'b0, 1'b0, 1'b1);
    por_n = 1'b1;
    tick();

    for (int v = 0; v < 10; v++) begin
      ce_n = VEC[v][7]; rst = VEC[v][6];
      tick();
      chk_out($sformatf("R3/R5/R7/R9 vec%0d", v), VEC[v][5], PAT[VEC[v][3:0]], VEC[v][7]);
    end

    // R2 / R4: bit 0 visible right after reset release, before a clock edge
    restart();
    chk_out("R4 bit0 on release", 1'b1, PAT[0], 1'b0);

    // R6: run to highest address, then one past, then stay
    for (int k = 1; k < D; k++) tick();
    chk_out("R6 highest addr", 1'b1, PAT[D-1], 1'b0);
    tick();
    chk_out("R6 past end reads bit0", 1'b1, PAT[0], 1'b0);
    for (int k = 0; k < 3; k++) tick();
    chk_out("R6 stays at end", 1'b1, PAT[0], 1'b0);

    // R8: write while selected is ignored
    restart();
    wr_en = 1'b1; wr_addr = AW'(1); wr_bit = ~PAT[1];
    tick();
    wr_en = 1'b0;
    chk_out("R8 write while selected ignored", 1'b1, PAT[1], 1'b0);

    // R8: write in standby takes effect
    ce_n = 1'b1; wr_en = 1'b1; wr_addr = AW'(1); wr_bit = ~PAT[1];
    tick();
    wr_en = 1'b0;
    chk_out("R5 standby during write", 1'b0, 1'b0, 1'b1);
    restart();
    tick();
    chk_out("R8 standby write stored", 1'b1, ~PAT[1], 1'b0);

    // R1: power-on reset clears counter
    tick(); tick();
    por_n = 1'b0;
    #1;
    por_n = 1'b1;
    #1;
    chk_out("R1 por clears counter", 1'b1, PAT[0], 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule